// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Drive Sequencer

This block sits between the PWM modulator and the analog gate drivers of a synchronous buck stage. It turns one PWM demand into two enables, one for the high-side switch and one for the low-side switch, and it never lets them overlap. The dead time between the two is not a fixed delay. It is set by sensed conditions: after the high side turns off, the low side waits for the switch node to be reported below its threshold. After the low side turns off, the high side waits for the low-side gate to be reported discharged. A programmable minimum count of clock cycles can stretch either gap, and a timeout stops a missing switch-node report from stalling the low side.

The block also enforces a maximum duty cycle by capping each high-side pulse at a fixed number of clocks. A pulse cut short this way is not restarted until the PWM demand has been seen low again. A PWM demand that stays low gives 0 % duty: the low side stays on and the high side never fires. The sequencer's global enable overrides everything and drops both enables, covering shutdown, disable and latch-off.

The controller has four states: both-off (also the low-to-high dead interval), high-on, dead-high-to-low and low-on. All transitions happen on rising clock edges. Each output is a decode of the state register, so an output changes one clock edge after the input sample that caused it.

Top module: `dtg_gate_drive`

## Requirements
- R1: `hs_en_o` and `ls_en_o` are never both high in the same clock cycle.
- R2: During reset both outputs are low. A clock edge that samples `drv_en_i` low leaves both outputs low in the following cycle.
- R3: After a high-side pulse ends, `ls_en_o` rises only at an edge where `sw_low_i` is sampled high and the dead interval has lasted at least max(`min_dead_i`, 1) cycles. The timeout case in R4 is the only exception.
- R4: If `sw_low_i` stays low, `ls_en_o` rises after exactly `TMO_CLKS` dead cycles, which is 40 by default.
- R5: `hs_en_o` rises only from the both-off state, at an edge that samples `pwm_i` high and `lsg_low_i` high, once at least max(`min_dead_i`, 1) cycles have passed in both-off.
- R6: A high-side pulse lasts at most `MAX_ON` = `PERIOD_CLKS`*`DUTY_MAX_PCT`/100 cycles, which is 95 by default. After such a forced turn-off, `hs_en_o` stays low while `pwm_i` stays high, and it may fire again only after `pwm_i` has been sampled low.
- R7: While `pwm_i` stays low with the block enabled, `hs_en_o` stays low and `ls_en_o` stays high (0 % duty).
- R8: An edge that samples `pwm_i` low while the high side is on turns `hs_en_o` off for the next cycle.
- R9: From both-off with `pwm_i` low, `ls_en_o` rises only at an edge that samples `sw_low_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock; all transitions on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_i | input | 1 | PWM demand, high requests high-side conduction |
| sw_low_i | input | 1 | Switch node reported below its low threshold |
| lsg_low_i | input | 1 | Low-side gate reported discharged |
| drv_en_i | input | 1 | Global driver enable from the power sequencer |
| min_dead_i | input | CNT_W (4) | Minimum dead interval in clock cycles |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
A wrong state would show up at the ports within one clock edge: both enables high together, an enable rising without its sensed precondition, or an enable held through a disable. A dead or on-time counter that is off by one shows up as a low-side turn-on or a forced high-side turn-off that is one cycle early or late. For that reason the bench samples the exact edge for the minimum dead interval, the timeout and the pulse cap. A stuck block flag would show up either as a high-side pulse that never returns after the PWM demand re-arms, or as a pulse that fires again while the demand is still high.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HI   = 2'd1,
    ST_DHL  = 2'd2,
    ST_LO   = 2'd3
  } dtg_state_t;
endpackage

// File: rtl/dtg_sat_counter.sv
module dtg_sat_counter #(
  parameter int W   = 6,
  parameter int MAX = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CAP = W'(MAX);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;

  always_comb begin
    if (restart_i)        cnt_d = ONE;
    else if (cnt_o < CAP) cnt_d = cnt_o + ONE;
    else                  cnt_d = cnt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= ONE;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/dtg_next_state.sv
module dtg_next_state
  import dtg_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DEAD_W = 6,
  parameter int ON_W   = 7,
  parameter int TMO    = 40,
  parameter int MAX_ON = 95
) (
  input  dtg_state_t        state_i,
  input  logic              pwm_i,
  input  logic              sw_low_i,
  input  logic              lsg_low_i,
  input  logic              drv_en_i,
  input  logic              blk_i,
  input  logic [DEAD_W-1:0] dead_cnt_i,
  input  logic [ON_W-1:0]   on_cnt_i,
  input  logic [CNT_W-1:0]  min_dead_i,
  output dtg_state_t        state_o,
  output logic              blk_o
);
  logic min_ok, tmo_hit, on_full;

  assign min_ok  = dead_cnt_i >= DEAD_W'(min_dead_i);
  assign tmo_hit = dead_cnt_i >= DEAD_W'(TMO);
  assign on_full = on_cnt_i >= ON_W'(MAX_ON);

  always_comb begin
    state_o = state_i;
    if (!drv_en_i) begin
      state_o = ST_OFF;
    end else begin
      unique case (state_i)
        ST_OFF: begin
          if (pwm_i && !blk_i) begin
            if (lsg_low_i && min_ok) state_o = ST_HI;
          end else if (!pwm_i && sw_low_i) begin
            state_o = ST_LO;
          end
        end
        ST_HI:  if (!pwm_i || on_full) state_o = ST_DHL;
        ST_DHL: if ((sw_low_i && min_ok) || tmo_hit) state_o = ST_LO;
        ST_LO:  if (pwm_i && !blk_i) state_o = ST_OFF;
        default: state_o = ST_OFF;
      endcase
    end
  end

  always_comb begin
    if (!pwm_i)                        blk_o = 1'b0;
    else if (state_i == ST_HI && on_full) blk_o = 1'b1;
    else                               blk_o = blk_i;
  end
endmodule

// File: rtl/dtg_gate_drive.sv
module dtg_gate_drive
  import dtg_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int TMO_CLKS     = 40,
  parameter int PERIOD_CLKS  = 100,
  parameter int DUTY_MAX_PCT = 95
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             sw_low_i,
  input  logic             lsg_low_i,
  input  logic             drv_en_i,
  input  logic [CNT_W-1:0] min_dead_i,
  output logic             hs_en_o,
  output logic             ls_en_o
);
  localparam int MAX_ON  = (PERIOD_CLKS * DUTY_MAX_PCT) / 100;
  localparam int DEAD_CAP = (TMO_CLKS > (1 << CNT_W)) ? TMO_CLKS : (1 << CNT_W);
  localparam int DEAD_W  = $clog2(DEAD_CAP + 1);
  localparam int ON_W    = $clog2(MAX_ON + 1);

  dtg_state_t        state_q, state_d;
  logic              blk_q, blk_d;
  logic [DEAD_W-1:0] dead_cnt;
  logic [ON_W-1:0]   on_cnt;

  dtg_next_state #(
    .CNT_W(CNT_W), .DEAD_W(DEAD_W), .ON_W(ON_W),
    .TMO(TMO_CLKS), .MAX_ON(MAX_ON)
  ) u_ns (
    .state_i(state_q), .pwm_i(pwm_i), .sw_low_i(sw_low_i),
    .lsg_low_i(lsg_low_i), .drv_en_i(drv_en_i), .blk_i(blk_q),
    .dead_cnt_i(dead_cnt), .on_cnt_i(on_cnt), .min_dead_i(min_dead_i),
    .state_o(state_d), .blk_o(blk_d)
  );

  // cycles spent in the current state, restarted on each transition
  dtg_sat_counter #(.W(DEAD_W), .MAX(DEAD_CAP)) u_dead (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .restart_i(state_d != state_q), .cnt_o(dead_cnt)
  );

  // length of the running high-side pulse
  dtg_sat_counter #(.W(ON_W), .MAX(MAX_ON)) u_on (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .restart_i(state_q != ST_HI), .cnt_o(on_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      blk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
    end
  end

  assign hs_en_o = (state_q == ST_HI);
  assign ls_en_o = (state_q == ST_LO);
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int TMO_CLKS = 40,
  parameter int MAX_ON   = 95
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic sw_low_i,
  input logic lsg_low_i,
  input logic drv_en_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  localparam int RW = $clog2(((TMO_CLKS > MAX_ON) ? TMO_CLKS : MAX_ON) + 2);
  localparam logic [RW-1:0] RCAP = {RW{1'b1}};

  logic [RW-1:0] off_run, hs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_run <= '0;
      hs_run  <= '0;
    end else begin
      if (!hs_en_o && !ls_en_o) off_run <= (off_run == RCAP) ? off_run : off_run + 1'b1;
      else                      off_run <= '0;
      if (hs_en_o) hs_run <= (hs_run == RCAP) ? hs_run : hs_run + 1'b1;
      else         hs_run <= '0;
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_disable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_i |=> (!hs_en_o && !ls_en_o));

  assert_ls_waits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> ($past(sw_low_i) || ($past(off_run) >= RW'(TMO_CLKS - 1))));

  assert_hs_waits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> ($past(lsg_low_i) && $past(pwm_i) && !$past(ls_en_o)));

  assert_pulse_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> (hs_run < RW'(MAX_ON)));

  assert_pwm_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o && !pwm_i) |=> !hs_en_o);
endmodule

bind dtg_gate_drive dtg_checker #(
  .TMO_CLKS(TMO_CLKS),
  .MAX_ON((PERIOD_CLKS * DUTY_MAX_PCT) / 100)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .sw_low_i(sw_low_i),
  .lsg_low_i(lsg_low_i), .drv_en_i(drv_en_i),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/tb_dtg_gate_drive.sv
`timescale 1ns/1ps
module tb_dtg_gate_drive;
  localparam int CNT_W  = 4;
  localparam int TMO    = 40;
  localparam int PERIOD = 100;
  localparam int DUTY   = 95;
  localparam int MAX_ON = (PERIOD * DUTY) / 100;

  logic clk, rst_n, pwm, sw_low, lsg_low, drv_en;
  logic [CNT_W-1:0] min_dead;
  logic hs, ls;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dtg_gate_drive #(.CNT_W(CNT_W), .TMO_CLKS(TMO), .PERIOD_CLKS(PERIOD),
                   .DUTY_MAX_PCT(DUTY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .sw_low_i(sw_low),
    .lsg_low_i(lsg_low), .drv_en_i(drv_en), .min_dead_i(min_dead),
    .hs_en_o(hs), .ls_en_o(ls)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model built from the requirements: 0 off, 1 high, 2 dead, 3 low
  int m_st, m_cnt, m_on;
  bit m_blk;

  function automatic int next_st(int st, int cnt, int on, bit blk);
    if (!drv_en) return 0;
    case (st)
      0: if (pwm && !blk) return (lsg_low && cnt >= min_dead) ? 1 : 0;
         else if (!pwm && sw_low) return 3;
         else return 0;
      1: return (!pwm || on >= MAX_ON) ? 2 : 1;
      2: return ((sw_low && cnt >= min_dead) || cnt >= TMO) ? 3 : 2;
      default: return (pwm && !blk) ? 0 : 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 1; m_on = 1; m_blk = 0;
    end else begin
      int ns;
      bit nb;
      ns = next_st(m_st, m_cnt, m_on, m_blk);
      nb = !pwm ? 1'b0 : ((m_st == 1 && m_on >= MAX_ON) ? 1'b1 : m_blk);
      m_on  = (m_st != 1) ? 1 : m_on + 1;
      m_cnt = (ns != m_st) ? 1 : m_cnt + 1;
      m_st  = ns;
      m_blk = nb;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // every cycle after reset: outputs against the model, and no overlap
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hs, (m_st == 1), "R3 R5 R6 R9 model hs");
      chk(ls, (m_st == 3), "R3 R4 R9 model ls");
      chk(hs && ls, 1'b0, "R1 overlap");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd2117));
    rst_n = 0; pwm = 0; sw_low = 0; lsg_low = 0; drv_en = 0; min_dead = 4'd3;
    step(3);
    chk(hs || ls, 1'b0, "R2 reset outputs low");
    rst_n = 1;
    drv_en = 1;
    step(3);
    chk(ls, 1'b0, "R9 no low side without switch node low");
    sw_low = 1;
    step(1);
    chk(ls, 1'b1, "R9 low side once switch node low");

    pwm = 1; lsg_low = 0;
    step(1);
    chk(ls, 1'b0, "R1 low side off on pwm rise");
    chk(hs, 1'b0, "R1 high side waits");
    step(4);
    chk(hs, 1'b0, "R5 high side held while low gate not low");
    lsg_low = 1;
    step(1);
    chk(hs, 1'b1, "R5 high side after low gate low");

    pwm = 0; sw_low = 0;
    step(1);
    chk(hs, 1'b0, "R8 high side off on pwm fall");
    step(TMO - 1);
    chk(ls, 1'b0, "R4 no low side before timeout");
    step(1);
    chk(ls, 1'b1, "R4 low side at timeout");

    pwm = 1; sw_low = 1;
    step(3);
    chk(hs, 1'b0, "R5 minimum dead interval honoured");
    step(1);
    chk(hs, 1'b1, "R5 high side after minimum dead");

    pwm = 0;
    step(1);
    chk(hs, 1'b0, "R8 high side off");
    step(2);
    chk(ls, 1'b0, "R3 low side held for minimum dead");
    step(1);
    chk(ls, 1'b1, "R3 low side after minimum dead with switch node low");

    // pulse cap
    pwm = 1;
    n = 0;
    while (!hs && n < 50) begin step(1); n++; end
    n = 0;
    while (hs && n < 300) begin step(1); n++; end
    checks++;
    if (n != MAX_ON) begin
      errors++;
      $display("FAIL R6 pulse length actual=%0d expected=%0d", n, MAX_ON);
    end
    ok = 1;
    for (int i = 0; i < 30; i++) begin step(1); if (hs) ok = 0; end
    chk(ok, 1'b1, "R6 no refire while pwm high");
    pwm = 0;
    step(2);
    pwm = 1;
    ok = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (hs) ok = 1; end
    chk(ok, 1'b1, "R6 refire after pwm seen low");

    // zero duty
    pwm = 0;
    step(8);
    ok = 1;
    for (int i = 0; i < 200; i++) begin step(1); if (hs || !ls) ok = 0; end
    chk(ok, 1'b1, "R7 zero duty keeps low side on");

    // disable during a pulse
    pwm = 1;
    n = 0;
    while (!hs && n < 50) begin step(1); n++; end
    chk(hs, 1'b1, "R5 pulse before disable");
    drv_en = 0;
    step(1);
    chk(hs || ls, 1'b0, "R2 disable drops both");
    step(5);
    chk(hs || ls, 1'b0, "R2 disable holds both low");
    drv_en = 1;

    // constrained random traffic, compared cycle by cycle against the model
    n = 0;
    for (int c = 0; c < 6000; c++) begin
      if (n == 0) begin
        pwm = ~pwm;
        n = pwm ? (1 + $urandom % 120) : ($urandom % 30);
      end else n--;
      sw_low  = ($urandom % 4) != 0;
      lsg_low = ($urandom % 3) != 0;
      drv_en  = ($urandom % 300) != 0;
      if (c % 250 == 0) min_dead = CNT_W'($urandom % 16);
      step(1);
    end
    finish_run();
  end
endmodule